// File: doc/BRIEF.md
# Multi-Channel Tagged Debug FIFO

This peripheral carries 32-bit words between software and a debug probe on sixteen logical channels while storing them in only two queues. Software writes a word to one of sixteen transmit addresses. The address picks the channel number, and the word enters one shared transmit queue together with a 4-bit channel tag. The probe side takes tagged words from that queue through a valid/ready port. In the other direction, the probe offers tagged words through a second valid/ready port, and they are kept in a shared receive queue. Software reads the status register to learn which channel the oldest received word belongs to, then reads the receive register to take that word.

A configuration register holds two 2-bit fields. Each field picks one of four conditions, per direction, that drive a level interrupt. The same register reports the depth of both queues. The register port is a simple select/write strobe with combinational read data. A read of the receive register removes the head word at the clock edge that ends the access.

Top module: `dbg_chan_fifo`

## Requirements
- R1: After reset the control register (0x00) reads 0, the configuration register (0x08) reads 0 in bits 19:16, the status register (0x10) reads 0x0000000A (both queues empty), and `irq` is low.
- R2: Configuration bits 15:8 always read the transmit depth and bits 7:0 always read the receive depth. Writes to those bits, and to bits 31:20, have no effect. Bits 19:16 are read/write.
- R3: A write to address 0x20 + 8·n (n = 0..15) queues the write data tagged with channel n. The probe port presents queued words in write order on `ptx_data`/`ptx_chan` and removes one at each cycle where `ptx_valid` and `ptx_ready` are both high.
- R4: A transmit write while the transmit queue is full is dropped and sets control bit 0. Writing 1 to control bit 0 clears it, and writing 0 leaves it unchanged.
- R5: Status bits 31:24 hold the transmit occupancy and bits 23:16 hold the receive occupancy.
- R6: Status bits 7:4 give the channel of the oldest received word (0 when the queue is empty). Bit 3 is receive-empty, bit 2 receive-full, bit 1 transmit-empty and bit 0 transmit-full.
- R7: A read of address 0x18 returns the oldest received word and removes it. On an empty receive queue, the read returns 0 and changes nothing.
- R8: Configuration bits 19:18 select the transmit interrupt condition: 0 none, 1 queue empty, 2 queue not full, 3 occupancy·4 ≤ depth.
- R9: Configuration bits 17:16 select the receive interrupt condition: 0 none, 1 queue full, 2 queue not empty, 3 occupancy·4 ≥ 3·depth.
- R10: `irq` is the OR of the two selected conditions, evaluated from the current state in every cycle.
- R11: `prx_ready` is low while the receive queue is full, and a word offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| ptx_valid | output | 1 | Transmit word available to probe |
| ptx_ready | input | 1 | Probe accepts transmit word |
| ptx_data | output | 32 | Transmit word |
| ptx_chan | output | 4 | Channel tag of transmit word |
| prx_valid | input | 1 | Probe offers a receive word |
| prx_ready | output | 1 | Receive queue can take a word |
| prx_data | input | 32 | Receive word |
| prx_chan | input | 4 | Channel tag of receive word |

## Verification
The bench builds the block with both depths set to 4. This puts the full, quarter and three-quarter thresholds only one or two words apart, so every interrupt selection can be switched on and off with a handful of transfers. It also lets the bench reach the dropped-write and refused-receive cases within a few cycles. The transmit words are driven on channels 0, 15 and others in between, which exercises the two ends of the channel address range.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int CHW = 4;
  localparam int WW  = 32;

  localparam logic [7:0] OFS_CTL  = 8'h00;
  localparam logic [7:0] OFS_CFG  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_RX   = 8'h18;

  typedef enum logic [1:0] {TXI_OFF, TXI_EMPTY, TXI_NOTFULL, TXI_LOW} tx_irq_e;
  typedef enum logic [1:0] {RXI_OFF, RXI_FULL, RXI_NOTEMPTY, RXI_HIGH} rx_irq_e;

  typedef struct packed {
    logic [CHW-1:0] chan;
    logic [WW-1:0]  data;
  } tword_t;

  // occupancy at or below a quarter of the depth
  function automatic logic is_low_mark(logic [31:0] cnt, logic [31:0] depth);
    return (cnt << 2) <= depth;
  endfunction

  // occupancy at or above three quarters of the depth
  function automatic logic is_high_mark(logic [31:0] cnt, logic [31:0] depth);
    return (cnt << 2) >= (depth * 32'd3);
  endfunction

  // transmit window: 0x20..0x98 in steps of 8
  function automatic logic tx_hit(logic [7:0] a);
    return (a[2:0] == 3'b000) && (a[7:3] >= 5'd4) && (a[7:3] <= 5'd19);
  endfunction

  function automatic logic [3:0] tx_chan(logic [7:0] a);
    return a[6:3] - 4'd4;
  endfunction
endpackage

// File: rtl/dcf_tagfifo.sv
module dcf_tagfifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 36,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  push_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> $stable(count));

  // R7
  pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> $stable(count));

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/dcf_irq.sv
module dcf_irq
  import dcf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tx_irq_e        tx_sel,
  input  rx_irq_e        rx_sel,
  input  logic [TCW-1:0] tx_cnt,
  input  logic [RCW-1:0] rx_cnt,
  output logic           irq
);
  logic tx_cond, rx_cond;

  always_comb begin
    unique case (tx_sel)
      TXI_OFF:     tx_cond = 1'b0;
      TXI_EMPTY:   tx_cond = (tx_cnt == '0);
      TXI_NOTFULL: tx_cond = (tx_cnt != TCW'(TX_DEPTH));
      TXI_LOW:     tx_cond = is_low_mark(32'(tx_cnt), 32'(TX_DEPTH));
      default:     tx_cond = 1'b0;
    endcase
  end

  always_comb begin
    unique case (rx_sel)
      RXI_OFF:      rx_cond = 1'b0;
      RXI_FULL:     rx_cond = (rx_cnt == RCW'(RX_DEPTH));
      RXI_NOTEMPTY: rx_cond = (rx_cnt != '0);
      RXI_HIGH:     rx_cond = is_high_mark(32'(rx_cnt), 32'(RX_DEPTH));
      default:      rx_cond = 1'b0;
    endcase
  end

  assign irq = tx_cond | rx_cond;

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == TXI_OFF && rx_sel == RXI_OFF) |-> !irq);

  // R8
  tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == TXI_EMPTY && tx_cnt == '0) |-> irq);

  // R9
  rx_full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel == RXI_FULL && rx_cnt == RCW'(RX_DEPTH)) |-> irq);
endmodule

// File: rtl/dbg_chan_fifo.sv
module dbg_chan_fifo
  import dcf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        ptx_valid,
  input  logic        ptx_ready,
  output logic [31:0] ptx_data,
  output logic [3:0]  ptx_chan,
  input  logic        prx_valid,
  output logic        prx_ready,
  input  logic [31:0] prx_data,
  input  logic [3:0]  prx_chan
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int TWW = $bits(tword_t);

  // named access events
  logic bus_wr, bus_rd;
  logic tx_wr_evt, tx_drop_evt, ctl_wr_evt, cfg_wr_evt, rx_rd_evt;

  logic ovf_q;
  tx_irq_e tx_sel_q;
  rx_irq_e rx_sel_q;

  tword_t tx_in, tx_head, rx_in, rx_head;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [3:0] head_chan;

  assign bus_wr      = reg_sel && reg_wr;
  assign bus_rd      = reg_sel && !reg_wr;
  assign tx_wr_evt   = bus_wr && tx_hit(reg_addr);
  assign tx_drop_evt = tx_wr_evt && tx_full;
  assign ctl_wr_evt  = bus_wr && (reg_addr == OFS_CTL);
  assign cfg_wr_evt  = bus_wr && (reg_addr == OFS_CFG);
  assign rx_rd_evt   = bus_rd && (reg_addr == OFS_RX);

  assign tx_in.chan = tx_chan(reg_addr);
  assign tx_in.data = reg_wdata;

  dcf_tagfifo #(.DEPTH(TX_DEPTH), .DW(TWW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (tx_wr_evt),
    .push_data (tx_in),
    .pop_req   (ptx_ready),
    .head      (tx_head),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  assign ptx_valid = !tx_empty;
  assign ptx_data  = tx_head.data;
  assign ptx_chan  = tx_head.chan;

  assign rx_in.chan = prx_chan;
  assign rx_in.data = prx_data;
  assign prx_ready  = !rx_full;

  dcf_tagfifo #(.DEPTH(RX_DEPTH), .DW(TWW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (prx_valid),
    .push_data (rx_in),
    .pop_req   (rx_rd_evt),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign head_chan = rx_empty ? 4'd0 : rx_head.chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (tx_drop_evt) begin
      ovf_q <= 1'b1;
    end else if (ctl_wr_evt && reg_wdata[0]) begin
      ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel_q <= TXI_OFF;
      rx_sel_q <= RXI_OFF;
    end else if (cfg_wr_evt) begin
      tx_sel_q <= tx_irq_e'(reg_wdata[19:18]);
      rx_sel_q <= rx_irq_e'(reg_wdata[17:16]);
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTL:  reg_rdata = {31'b0, ovf_q};
      OFS_CFG:  reg_rdata = {12'b0, tx_sel_q, rx_sel_q, 8'(TX_DEPTH), 8'(RX_DEPTH)};
      OFS_STAT: reg_rdata = {8'(tx_cnt), 8'(rx_cnt), 8'b0, head_chan,
                             rx_empty, rx_full, tx_empty, tx_full};
      OFS_RX:   reg_rdata = rx_empty ? 32'b0 : rx_head.data;
      default:  reg_rdata = 32'b0;
    endcase
  end

  dcf_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_sel (tx_sel_q),
    .rx_sel (rx_sel_q),
    .tx_cnt (tx_cnt),
    .rx_cnt (rx_cnt),
    .irq    (irq)
  );

  // R4
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop_evt |=> ovf_q);

  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_evt && rx_empty) |-> (reg_rdata == 32'b0));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptx_valid && !ptx_ready) |=> (ptx_valid && $stable(ptx_data) && $stable(ptx_chan)));
endmodule

// File: tb/sim_dbg_chan_fifo.sv
module sim_dbg_chan_fifo;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, ptx_valid, ptx_ready = 1'b0;
  logic [31:0] ptx_data;
  logic [3:0]  ptx_chan;
  logic        prx_valid = 1'b0, prx_ready;
  logic [31:0] prx_data = '0;
  logic [3:0]  prx_chan = '0;

  int n_chk = 0, n_bad = 0;
  logic [35:0] txq[$];
  logic [35:0] rxq[$];

  dbg_chan_fifo #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ptx_valid(ptx_valid), .ptx_ready(ptx_ready),
    .ptx_data(ptx_data), .ptx_chan(ptx_chan), .prx_valid(prx_valid),
    .prx_ready(prx_ready), .prx_data(prx_data), .prx_chan(prx_chan)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_stat(int txc, int rxc, logic [3:0] ch);
    return {8'(txc), 8'(rxc), 8'h00, ch, rxc == 0, rxc == RXD, txc == 0, txc == TXD};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  // driver: transmit write, expected item queued only when it should be kept
  task automatic tx_push(input int ch, input logic [31:0] d, input bit keep);
    wr(8'(8'h20 + 8 * ch), d);
    if (keep) txq.push_back({4'(ch), d});
  endtask

  task automatic rx_send(input logic [3:0] ch, input logic [31:0] d, output logic took);
    @(negedge clk);
    prx_valid = 1'b1; prx_chan = ch; prx_data = d;
    #1 took = prx_ready;
    @(negedge clk);
    prx_valid = 1'b0;
    if (took) rxq.push_back({ch, d});
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1 check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic drain();
    ptx_ready = 1'b1;
    while (txq.size() != 0) @(negedge clk);
    ptx_ready = 1'b0;
  endtask

  // monitor: compare each handshaken transmit word against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && ptx_valid && ptx_ready) begin
      if (txq.size() == 0) begin
        check("R3 unexpected tx word", ptx_data, 32'hxxxxxxxx);
      end else begin
        logic [35:0] e;
        e = txq.pop_front();
        check("R3 tx data", ptx_data, e[31:0]);
        check("R3 tx chan", {28'b0, ptx_chan}, {28'b0, e[35:32]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic took;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, d); check("R1 status", d, 32'h0000000A);
    rd(8'h08, d); check("R1 config", d, 32'h00000404);
    rd(8'h00, d); check("R1 control", d, 32'h0);
    chk_irq("R1 irq", 1'b0);

    // R2 depth fields read-only, selects writable
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08, d); check("R2 config", d, 32'h000F0404);
    chk_irq("R8 low-mark empty", 1'b1);
    wr(8'h08, 32'h0);
    chk_irq("R10 both off", 1'b0);

    // R3 / R5 tagged transmit, channels 0, 5, 15
    tx_push(0, 32'hA0A0_0001, 1);
    tx_push(5, 32'hB5B5_0002, 1);
    tx_push(15, 32'hCFCF_0003, 1);
    rd(8'h10, d); check("R5 tx occupancy", d, mk_stat(3, 0, 0));
    drain();
    rd(8'h10, d); check("R6 tx empty after drain", d, mk_stat(0, 0, 0));

    // R4 overflow drop and write-1-to-clear
    for (int i = 1; i <= 4; i++) tx_push(i, 32'h4400_0000 + i, 1);
    tx_push(7, 32'hDEAD_BEEF, 0);
    rd(8'h10, d); check("R4 full status", d, mk_stat(4, 0, 0));
    rd(8'h00, d); check("R4 flag set", d, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R4 write 0 keeps flag", d, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R4 write 1 clears", d, 32'h0);
    drain();

    // R8 transmit interrupt selects
    wr(8'h08, 32'h00040000); chk_irq("R8 empty sel, empty", 1'b1);
    tx_push(2, 32'h8000_0001, 1); chk_irq("R8 empty sel, 1 word", 1'b0);
    wr(8'h08, 32'h000C0000); chk_irq("R8 low sel, 1 word", 1'b1);
    tx_push(3, 32'h8000_0002, 1); chk_irq("R8 low sel, 2 words", 1'b0);
    wr(8'h08, 32'h00080000); chk_irq("R8 notfull sel, 2 words", 1'b1);
    tx_push(4, 32'h8000_0003, 1);
    tx_push(6, 32'h8000_0004, 1); chk_irq("R8 notfull sel, full", 1'b0);
    wr(8'h08, 32'h0); chk_irq("R8 off sel", 1'b0);
    drain();

    // R9 / R6 / R11 receive side
    wr(8'h08, 32'h00020000); chk_irq("R9 notempty sel, empty", 1'b0);
    rx_send(4'd9, 32'h9999_000A, took); chk_irq("R9 notempty sel, 1 word", 1'b1);
    rx_send(4'd3, 32'h3333_000B, took);
    rd(8'h10, d); check("R6 head chan 9", d, mk_stat(0, 2, 4'd9));
    wr(8'h08, 32'h00030000); chk_irq("R9 high sel, 2 words", 1'b0);
    rx_send(4'd6, 32'h6666_000C, took); chk_irq("R9 high sel, 3 words", 1'b1);
    wr(8'h08, 32'h00010000); chk_irq("R9 full sel, 3 words", 1'b0);
    rx_send(4'd12, 32'hCCCC_000D, took); chk_irq("R9 full sel, full", 1'b1);
    rd(8'h10, d); check("R6 full status", d, mk_stat(0, 4, 4'd9));
    rx_send(4'd1, 32'h1111_000E, took);
    check("R11 ready low when full", {31'b0, took}, 32'h0);
    rd(8'h10, d); check("R11 status unchanged", d, mk_stat(0, 4, 4'd9));
    for (int i = 0; i < 4; i++) begin
      logic [35:0] e;
      e = rxq.pop_front();
      rd(8'h10, d); check("R6 head chan", {28'b0, d[7:4]}, {28'b0, e[35:32]});
      rd(8'h18, d); check("R7 rx data", d, e[31:0]);
    end
    rd(8'h18, d); check("R7 empty read", d, 32'h0);
    rd(8'h10, d); check("R7 empty read no change", d, mk_stat(0, 0, 0));

    // R10 OR of both directions
    wr(8'h08, 32'h00060000); chk_irq("R10 tx cond only", 1'b1);
    tx_push(8, 32'h1010_0001, 1); chk_irq("R10 neither cond", 1'b0);
    rx_send(4'd2, 32'h2020_0002, took); chk_irq("R10 rx cond only", 1'b1);
    drain();
    rd(8'h18, d); check("R7 final rx", d, 32'h2020_0002);
    void'(rxq.pop_front());

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule